// File: doc/BRIEF.md
# Bit-Granular Instruction Field Extractor

This block slices fields of any width from 1 to 32 bits out of an instruction stream that arrives one byte at a time. Neither instructions nor their fields line up with byte boundaries. An instruction can be as short as 6 bits or longer than 300 bits, so one instruction may cover many fetched bytes. Incoming bytes are appended to a 40-bit staging buffer: a 32-bit extraction window plus one byte of headroom. A sequencing state machine downstream asks for one field after another. For each grant the block returns the oldest bits of the buffer, right-justified. It then shifts the buffer by the field width through a logarithmic shifter and moves a bit-resolution pointer forward by the same amount.

A redirect input loads the pointer with any bit address, including one in the middle of a byte. The redirect empties the buffer and issues the byte-aligned address from which the stream must restart. From the first byte that arrives after it, the block discards the bits below the new bit offset, so the next field begins exactly at the target bit.

Top module: `bitfield_extractor`

## Requirements
- R1: A granted field holds the next `req_width` stream bits with the earliest bit at bit 0. Stream bits are ordered byte by byte, and within each byte from bit 0 upward. The field appears on `fld_data` in the cycle after the grant.
- R2: Every `fld_data` bit at position `req_width` and above is zero.
- R3: `req_ready` is high only when `req_width` lies in 1..32 and the buffer holds at least `req_width` bits. No redirect may be present that cycle. Otherwise the request stalls and bytes are still accepted.
- R4: `in_ready` is high only when the buffer holds 32 bits or fewer, so the 40-bit buffer never overflows.
- R5: After each grant, `bit_ptr` rises by exactly `req_width`, with a carry from the bit offset into the byte address.
- R6: In the cycle after `redir_valid`, `bit_ptr` equals the redirect bit address. `fetch_valid` pulses for that one cycle, and `fetch_addr` equals the redirect address shifted right by 3.
- R7: After a redirect, the first granted field starts at bit (address mod 8) of the first byte accepted. The bits below that offset are dropped.
- R8: While `redir_valid` is high, `in_ready` and `req_ready` are low, so no byte is taken and no field is granted in that cycle.
- R9: After reset, `bit_ptr` is 0 and the buffer is empty. `fld_valid` and `fetch_valid` are low, and the stream starts at bit 0 of the first byte.
- R10: `fld_valid` is high in exactly the cycles that follow a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte offered |
| in_byte | input | 8 | Stream byte, bit 0 earliest |
| in_ready | output | 1 | Byte accepted this cycle when in_valid is high |
| req_valid | input | 1 | Field requested |
| req_width | input | 6 | Requested width, 1..32 |
| req_ready | output | 1 | Request granted this cycle when req_valid is high |
| fld_valid | output | 1 | Field output valid |
| fld_data | output | 32 | Extracted field, right-justified |
| redir_valid | input | 1 | Load a new bit address |
| redir_addr | input | 16 | New bit address |
| fetch_valid | output | 1 | Restart fetch request pulse |
| fetch_addr | output | 13 | Byte address of restart |
| bit_ptr | output | 16 | Bit address of the next field |

## Verification
The bench aims at redirects to odd bit offsets. A design that forgot to drop the leading bits would return fields shifted by that offset. It also aims at full 32-bit requests against a nearly empty buffer. A wrong fill compare would grant stale or zero bits there, and a wrong headroom check would accept a byte into a full buffer and overwrite live bits. Grants and byte arrivals in the same cycle check that the new byte lands right after the bits that remain. Redirects that coincide with offered bytes and requests check that neither handshake completes in that cycle.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;

    localparam int WIN_W  = 32;
    localparam int BYTE_W = 8;
    localparam int BUF_W  = WIN_W + BYTE_W;
    localparam int CNT_W  = $clog2(BUF_W + 1);
    localparam int WID_W  = $clog2(WIN_W + 1);
    localparam int PTR_W  = 16;
    localparam int OFS_W  = $clog2(BYTE_W);

    typedef enum logic [0:0] {
        ALIGN_DONE = 1'b0,
        ALIGN_WAIT = 1'b1
    } align_e;

    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] fill;
    } stage_t;

    function automatic logic [WIN_W-1:0] field_mask(input logic [WID_W-1:0] w);
        logic [WIN_W-1:0] m;
        m = '0;
        for (int i = 0; i < WIN_W; i++) begin
            if (i < int'(w)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/bit_shr.sv
module bit_shr #(
    parameter int W    = 40,
    parameter int SH_W = 6
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    logic [W-1:0] stg [0:SH_W];

    assign stg[0] = din;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        if (STEP < W) begin : g_shift
            assign stg[i+1] = amt[i] ? (stg[i] >> STEP) : stg[i];
        end else begin : g_clear
            assign stg[i+1] = amt[i] ? '0 : stg[i];
        end
    end

    assign dout = stg[SH_W];
endmodule

// File: rtl/stage_buffer.sv
module stage_buffer
    import bitfield_pkg::*;
#(
    parameter int BW = BUF_W,
    parameter int CW = CNT_W,
    parameter int WW = WID_W,
    parameter int YW = BYTE_W,
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [YW-1:0] push_byte,
    input  logic          skip_en,
    input  logic [OW-1:0] skip_amt,
    input  logic          pop,
    input  logic [WW-1:0] pop_w,
    output logic [BW-1:0] bits,
    output logic [CW-1:0] fill
);
    logic [BW-1:0] bits_q, bits_shr, bits_d;
    logic [CW-1:0] fill_q, fill_mid, fill_d, ins_len;
    logic [WW-1:0] shr_amt;
    logic [YW-1:0] ins_byte;

    assign shr_amt = pop ? pop_w : '0;

    bit_shr #(.W(BW), .SH_W(WW)) u_shr (
        .din  (bits_q),
        .amt  (shr_amt),
        .dout (bits_shr)
    );

    always_comb begin
        ins_byte = skip_en ? (push_byte >> skip_amt) : push_byte;
        ins_len  = skip_en ? (CW'(YW) - CW'(skip_amt)) : CW'(YW);
        fill_mid = pop ? (fill_q - CW'(pop_w)) : fill_q;
        bits_d   = bits_shr;
        fill_d   = fill_mid;
        if (push) begin
            bits_d = bits_shr | (BW'(ins_byte) << fill_mid);
            fill_d = fill_mid + ins_len;
        end
        if (flush) begin
            bits_d = '0;
            fill_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            fill_q <= '0;
        end else begin
            bits_q <= bits_d;
            fill_q <= fill_d;
        end
    end

    assign bits = bits_q;
    assign fill = fill_q;
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
    import bitfield_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int WW = WID_W,
    parameter int OW = OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redir,
    input  logic [PW-1:0] redir_addr,
    input  logic          adv,
    input  logic [WW-1:0] adv_w,
    input  logic          first_byte,
    output logic [PW-1:0] ptr,
    output logic          fetch_valid,
    output logic [PW-OW-1:0] fetch_addr,
    output align_e        align,
    output logic [OW-1:0] skip_amt
);
    logic [PW-1:0]    ptr_q;
    logic             fv_q;
    logic [PW-OW-1:0] fa_q;
    align_e           align_q;
    logic [OW-1:0]    skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            fv_q    <= 1'b0;
            fa_q    <= '0;
            align_q <= ALIGN_DONE;
            skip_q  <= '0;
        end else begin
            fv_q <= 1'b0;
            if (redir) begin
                ptr_q   <= redir_addr;
                fv_q    <= 1'b1;
                fa_q    <= redir_addr[PW-1:OW];
                align_q <= ALIGN_WAIT;
                skip_q  <= redir_addr[OW-1:0];
            end else begin
                if (adv) ptr_q <= ptr_q + PW'(adv_w);
                if (first_byte) align_q <= ALIGN_DONE;
            end
        end
    end

    assign ptr         = ptr_q;
    assign fetch_valid = fv_q;
    assign fetch_addr  = fa_q;
    assign align       = align_q;
    assign skip_amt    = skip_q;
endmodule

// File: rtl/field_out.sv
module field_out
    import bitfield_pkg::*;
#(
    parameter int FW = WIN_W,
    parameter int WW = WID_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [WW-1:0] width,
    input  logic [FW-1:0] window,
    output logic          fld_valid,
    output logic [FW-1:0] fld_data
);
    logic          v_q;
    logic [FW-1:0] d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            d_q <= '0;
        end else begin
            v_q <= take;
            if (take) d_q <= window & field_mask(width);
        end
    end

    assign fld_valid = v_q;
    assign fld_data  = d_q;
endmodule

// File: rtl/bitfield_extractor.sv
module bitfield_extractor
    import bitfield_pkg::*;
#(
    parameter int WIN   = WIN_W,
    parameter int BYTEW = BYTE_W,
    parameter int PW    = PTR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [BYTEW-1:0]         in_byte,
    output logic                     in_ready,
    input  logic                     req_valid,
    input  logic [$clog2(WIN+1)-1:0] req_width,
    output logic                     req_ready,
    output logic                     fld_valid,
    output logic [WIN-1:0]           fld_data,
    input  logic                     redir_valid,
    input  logic [PW-1:0]            redir_addr,
    output logic                     fetch_valid,
    output logic [PW-$clog2(BYTEW)-1:0] fetch_addr,
    output logic [PW-1:0]            bit_ptr
);
    localparam int BW  = WIN + BYTEW;
    localparam int CW  = $clog2(BW + 1);
    localparam int WW  = $clog2(WIN + 1);
    localparam int OW  = $clog2(BYTEW);
    localparam int ROOM = BW - BYTEW;

    logic [BW-1:0] bits;
    logic [CW-1:0] fill;
    logic          push, take, width_ok, first_byte;
    align_e        align;
    logic [OW-1:0] skip_amt;

    assign width_ok  = (req_width != '0) && (int'(req_width) <= WIN);
    assign req_ready = !redir_valid && (align == ALIGN_DONE) && width_ok
                       && (int'(fill) >= int'(req_width));
    assign in_ready  = !redir_valid && (int'(fill) <= ROOM);
    assign take      = req_valid && req_ready;
    assign push      = in_valid && in_ready;
    assign first_byte = push && (align == ALIGN_WAIT);

    stage_buffer #(.BW(BW), .CW(CW), .WW(WW), .YW(BYTEW), .OW(OW)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .flush     (redir_valid),
        .push      (push),
        .push_byte (in_byte),
        .skip_en   (first_byte),
        .skip_amt  (skip_amt),
        .pop       (take),
        .pop_w     (req_width),
        .bits      (bits),
        .fill      (fill)
    );

    ptr_unit #(.PW(PW), .WW(WW), .OW(OW)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .redir       (redir_valid),
        .redir_addr  (redir_addr),
        .adv         (take),
        .adv_w       (req_width),
        .first_byte  (first_byte),
        .ptr         (bit_ptr),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .align       (align),
        .skip_amt    (skip_amt)
    );

    field_out #(.FW(WIN), .WW(WW)) u_fld (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .width     (req_width),
        .window    (bits[WIN-1:0]),
        .fld_valid (fld_valid),
        .fld_data  (fld_data)
    );

    logic unused_hi;
    assign unused_hi = ^bits[BW-1:WIN];
endmodule

// File: rtl/bitfield_checks.sv
module bitfield_checks #(
    parameter int WIN = 32,
    parameter int PW  = 16,
    parameter int CW  = 6,
    parameter int WW  = 6,
    parameter int FAW = 13
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_ready,
    input logic           req_valid,
    input logic [WW-1:0]  req_width,
    input logic           req_ready,
    input logic           fld_valid,
    input logic [WIN-1:0] fld_data,
    input logic           redir_valid,
    input logic [PW-1:0]  redir_addr,
    input logic           fetch_valid,
    input logic [FAW-1:0] fetch_addr,
    input logic [PW-1:0]  bit_ptr,
    input logic [CW-1:0]  fill
);
    assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= WIN + 8);

    assert_push_room_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> int'(fill) <= WIN);

    assert_grant_fill_R3: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (int'(fill) >= int'(req_width)) && (req_width != '0));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> bit_ptr == $past(bit_ptr) + PW'($past(req_width)));

    assert_redir_load_R6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (bit_ptr == $past(redir_addr)) && fetch_valid
                        && (fetch_addr == FAW'($past(redir_addr) >> 3)));

    assert_redir_block_R8: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> !in_ready && !req_ready);

    assert_fld_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> fld_valid);

    assert_fld_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !fld_valid);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && int'(req_width) < WIN)
            |=> (fld_data >> $past(req_width)) == '0);
endmodule

bind bitfield_extractor bitfield_checks #(
    .WIN(WIN), .PW(PW), .CW(CW), .WW(WW), .FAW(PW - OW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .req_valid   (req_valid),
    .req_width   (req_width),
    .req_ready   (req_ready),
    .fld_valid   (fld_valid),
    .fld_data    (fld_data),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .bit_ptr     (bit_ptr),
    .fill        (fill)
);

// File: tb/sim_bitfield_extractor.sv
`timescale 1ns/1ps
module sim_bitfield_extractor;
    localparam int NBYTES = 128;
    localparam int NCYC   = 4000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, req_valid, req_ready;
    logic [7:0]  in_byte;
    logic [5:0]  req_width;
    logic        fld_valid, redir_valid, fetch_valid;
    logic [31:0] fld_data;
    logic [15:0] redir_addr, bit_ptr;
    logic [12:0] fetch_addr;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mem [0:NBYTES-1];

    always #4 clk = ~clk;

    bitfield_extractor u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .req_valid(req_valid), .req_width(req_width), .req_ready(req_ready),
        .fld_valid(fld_valid), .fld_data(fld_data),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .bit_ptr(bit_ptr)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] stream_bits(input int p, input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < w; i++) begin
            int b = p + i;
            if (b < NBYTES * 8) r[i] = mem[b >> 3][b & 7];
        end
        return r;
    endfunction

    initial begin
        #(8 * (NCYC + 200));
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int exp_ptr = 0;
        int feed = 0;
        bit pend_take = 0, pend_redir = 0;
        logic [31:0] pend_data = '0;
        int pend_fa = 0;
        int dir_addr [6] = '{13, 7, 0, 255, 407, 1};
        int dir_i = 0;

        void'($urandom(32'd2024));
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'($urandom);

        rst = 1'b1; in_valid = 0; in_byte = 0; req_valid = 0; req_width = 6'd1;
        redir_valid = 0; redir_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R9 bit_ptr", bit_ptr, 0);
        check("R9 fld_valid", fld_valid, 0);
        check("R9 fetch_valid", fetch_valid, 0);
        check("R9 in_ready", in_ready, 1);
        check("R9 req_ready empty", req_ready, 0);

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit br;
            int w, avail;
            bit exp_ir, exp_rr;
            @(negedge clk);
            if (pend_take) begin
                check("R10 fld_valid", fld_valid, 1);
                check("R1/R2/R7 fld_data", fld_data, pend_data);
            end else begin
                check("R10 fld_valid idle", fld_valid, 0);
            end
            check("R5/R6 bit_ptr", bit_ptr, exp_ptr & 16'hFFFF);
            check("R6 fetch_valid", fetch_valid, pend_redir);
            if (pend_redir) check("R6 fetch_addr", fetch_addr, pend_fa);
            pend_take = 0;
            pend_redir = 0;

            // directed: redirect to odd offsets, and a starved 32-bit request
            br = 0;
            if (cyc % 300 == 5 && dir_i < 6) begin
                br = 1; redir_addr = 16'(dir_addr[dir_i]); dir_i++;
            end else if (cyc > 2000 && $urandom_range(0, 39) == 0) begin
                br = 1; redir_addr = 16'($urandom_range(0, 800));
            end
            redir_valid = br;
            if (cyc >= 5 && cyc < 20) begin
                in_valid = 0; req_valid = 1; w = 32;
            end else begin
                in_valid = ($urandom_range(0, 3) != 0) && (feed < NBYTES);
                req_valid = ($urandom_range(0, 2) != 0);
                w = (cyc % 17 == 0) ? 32 : $urandom_range(1, 32);
            end
            in_byte = (feed < NBYTES) ? mem[feed] : 8'h00;
            req_width = 6'(w);
            #1;
            avail = feed * 8 - exp_ptr;
            exp_ir = !br && (avail <= 32);
            exp_rr = !br && (avail >= w);
            check("R4/R8 in_ready", in_ready, exp_ir);
            check("R3/R8 req_ready", req_ready, exp_rr);
            if (br) begin
                exp_ptr = int'(redir_addr);
                feed = exp_ptr >> 3;
                pend_redir = 1;
                pend_fa = exp_ptr >> 3;
            end else begin
                if (req_valid && exp_rr) begin
                    pend_take = 1;
                    pend_data = stream_bits(exp_ptr, w);
                    exp_ptr += w;
                end
                if (in_valid && exp_ir) feed++;
            end
        end
        @(negedge clk);
        if (pend_take) check("R1 final fld_data", fld_data, pend_data);
        check("R5 final bit_ptr", bit_ptr, exp_ptr & 16'hFFFF);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule